// File: doc/BRIEF.md
# Video Sync Generator with Per-Frame Width Change

This block drives the frame sync, line sync and data valid strobes of a video transmit interface. Software-style configuration inputs set the horizontal sync, back-porch and front-porch widths in pixel-clock cycles, the vertical sync, back-porch, front-porch and active line counts, and the horizontal resolution in pixels. The number of data-valid cycles in each active line is the resolution divided by the pixels carried per data word, rounded up.

The horizontal resolution may change from one frame to the next. A request can arrive at any time and is held until the next frame blanking interval. At the end of the last active line a fixed run of dummy blanking lines is inserted. The downstream controller sees an active-low reset pulse during the line-sync pulse of the first dummy line. The new resolution appears on the resolution output exactly as that pulse ends. The resolution and virtual-channel outputs only move while frame sync is low, so a downstream transmitter always sees them settled before a frame opens.

Top module: `vid_sync_gen`

## Requirements
- R1: While reset is asserted, frame_sync, line_sync and data_vld are low, ctrl_rst_n is high, res_out equals the HRES_INIT parameter and chan_out is zero.
- R2: Each line lasts sync + back porch + data words + front porch cycles. line_sync is high for the first sync cycles. data_vld rises exactly sync + back porch cycles after line_sync rises.
- R3: In every active line data_vld stays high without a gap for ceil(res_out / PIX_PER_WORD) cycles (PIX_PER_WORD = 4 in the bench).
- R4: A horizontal sync, back-porch or front-porch setting below 2 is used as 2.
- R5: A frame is v_sync_lines blanking lines, then v_back_lines lines, then v_act_lines active lines carrying data, then v_front_lines blanking lines. frame_sync is high exactly over the back-porch and active lines. Any vertical count below 1 is used as 1.
- R6: A resolution request (res_req_vld high for one cycle with res_req_val) is latched. res_out does not change while frame_sync is high; the request takes effect in the next frame blanking.
- R7: When a request is pending at the end of the last active line, NUM_DUMMY (default 2) extra blanking lines are inserted before the front-porch lines. With no pending request, none are inserted.
- R8: ctrl_rst_n is low exactly while line_sync is high in the first dummy line. res_out takes the requested value in the cycle that line_sync falls there.
- R9: chan_out copies chan_in at the first line of the vertical sync region and holds otherwise; a chan_in change while frame_sync is high does not reach chan_out before frame_sync falls.
- R10: res_out and chan_out never change in a cycle where frame_sync is high, including the cycle in which frame_sync rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sync_len | input | PORCH_W | Line-sync width in cycles |
| h_back_len | input | PORCH_W | Horizontal back porch in cycles |
| h_front_len | input | PORCH_W | Horizontal front porch in cycles |
| v_sync_lines | input | VCNT_W | Vertical sync lines |
| v_back_lines | input | VCNT_W | Vertical back-porch lines |
| v_act_lines | input | VCNT_W | Active lines per frame |
| v_front_lines | input | VCNT_W | Vertical front-porch lines |
| res_req_vld | input | 1 | One-cycle strobe for a new horizontal resolution |
| res_req_val | input | HRES_W | Requested horizontal resolution in pixels |
| chan_in | input | VC_W | Virtual channel to present from the next frame |
| frame_sync | output | 1 | High over the back-porch and active lines |
| line_sync | output | 1 | Line-sync pulse |
| data_vld | output | 1 | Pixel data word expected this cycle |
| ctrl_rst_n | output | 1 | Active-low controller reset pulse |
| res_out | output | HRES_W | Horizontal resolution in effect |
| chan_out | output | VC_W | Virtual channel in effect |

## Verification
The bench targets the clamp of porch and line counts below their minimums: a design without the clamp would emit one-cycle sync pulses or frames with no active line. It checks that valid runs round the word count up for resolutions that are not a multiple of the word size; a truncating design would drop the final partial word. It checks that dummy lines appear only after a request and that the controller reset lines up with the first dummy pulse. A design that applied the new width at the wrong moment would show the old value when the reset ends, or would change it while frame sync is high. A channel or resolution change requested in mid-frame must not leak into that frame.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

   // Vertical regions of a frame, in the order they are visited.
   typedef enum logic [2:0] {
      VP_SYNC   = 3'd0,
      VP_BACK   = 3'd1,
      VP_ACTIVE = 3'd2,
      VP_DUMMY  = 3'd3,
      VP_FRONT  = 3'd4
   } vphase_e;

   // Smallest legal horizontal region width (cycles) and vertical count (lines).
   localparam int unsigned H_MIN = 2;
   localparam int unsigned V_MIN = 1;

endpackage

// File: rtl/vsg_words.sv
module vsg_words #(
   parameter int unsigned HRES_W       = 16,
   parameter int unsigned PIX_PER_WORD = 4
) (
   input  logic [HRES_W-1:0] hres,
   output logic [HRES_W-1:0] words
);

   localparam int unsigned SUM_W = HRES_W + 1;
   localparam int unsigned SH    = (PIX_PER_WORD > 1) ? $clog2(PIX_PER_WORD) : 0;
   localparam bit          POW2  = ((PIX_PER_WORD & (PIX_PER_WORD - 1)) == 0);

   if (PIX_PER_WORD < 1) begin : g_bad_ppw
      $error("PIX_PER_WORD must be at least 1");
   end

   logic [SUM_W-1:0] sum;
   assign sum = {1'b0, hres} + SUM_W'(PIX_PER_WORD - 1);

   if (POW2) begin : g_shift
      logic [SUM_W-1:0] q;
      assign q     = sum >> SH;
      assign words = q[HRES_W-1:0];
   end else begin : g_div
      logic [SUM_W-1:0] q;
      assign q     = sum / SUM_W'(PIX_PER_WORD);
      assign words = q[HRES_W-1:0];
   end

endmodule

// File: rtl/vsg_hline.sv
module vsg_hline
   import vsg_pkg::*;
#(
   parameter int unsigned PORCH_W = 8,
   parameter int unsigned WORDS_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PORCH_W-1:0] h_sync_len,
   input  logic [PORCH_W-1:0] h_back_len,
   input  logic [PORCH_W-1:0] h_front_len,
   input  logic [WORDS_W-1:0] words,
   output logic               lsync,
   output logic               act_win,
   output logic               eol,
   output logic               pulse_last,
   output logic [WORDS_W-1:0] words_q
);

   localparam int unsigned CNT_W = WORDS_W + 2;

   if (PORCH_W > WORDS_W) begin : g_bad_width
      $error("PORCH_W must not exceed WORDS_W");
   end

   logic [PORCH_W-1:0] sync_e, back_e, front_e;
   logic [CNT_W-1:0]   beg_n, end_n, last_n;
   logic [CNT_W-1:0]   hcnt_q, sync_end_q, beg_q, end_q, last_q;
   logic               started_q;
   logic               load;

   // Widths below the legal minimum are raised to it.
   assign sync_e  = (h_sync_len  < PORCH_W'(H_MIN)) ? PORCH_W'(H_MIN) : h_sync_len;
   assign back_e  = (h_back_len  < PORCH_W'(H_MIN)) ? PORCH_W'(H_MIN) : h_back_len;
   assign front_e = (h_front_len < PORCH_W'(H_MIN)) ? PORCH_W'(H_MIN) : h_front_len;

   assign beg_n  = CNT_W'(sync_e) + CNT_W'(back_e);
   assign end_n  = beg_n + CNT_W'(words);
   assign last_n = end_n + CNT_W'(front_e) - CNT_W'(1);

   assign eol  = started_q && (hcnt_q == last_q);
   assign load = !started_q || eol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q  <= 1'b0;
         hcnt_q     <= '0;
         sync_end_q <= '0;
         beg_q      <= '0;
         end_q      <= '0;
         last_q     <= '0;
         words_q    <= '0;
      end else begin
         started_q <= 1'b1;
         if (load) begin
            hcnt_q     <= '0;
            sync_end_q <= CNT_W'(sync_e);
            beg_q      <= beg_n;
            end_q      <= end_n;
            last_q     <= last_n;
            words_q    <= words;
         end else begin
            hcnt_q <= hcnt_q + CNT_W'(1);
         end
      end
   end

   assign lsync      = started_q && (hcnt_q < sync_end_q);
   assign act_win    = started_q && (hcnt_q >= beg_q) && (hcnt_q < end_q);
   assign pulse_last = started_q && (hcnt_q == sync_end_q - CNT_W'(1));

   // R4
   sync_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lsync) |-> $past(lsync, 2));

endmodule

// File: rtl/vsg_vframe.sv
module vsg_vframe
   import vsg_pkg::*;
#(
   parameter int unsigned VCNT_W    = 8,
   parameter int unsigned HRES_W    = 16,
   parameter int unsigned VC_W      = 2,
   parameter int unsigned NUM_DUMMY = 2,
   parameter int unsigned HRES_INIT = 640
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eol,
   input  logic              pulse_last,
   input  logic [VCNT_W-1:0] v_sync_lines,
   input  logic [VCNT_W-1:0] v_back_lines,
   input  logic [VCNT_W-1:0] v_act_lines,
   input  logic [VCNT_W-1:0] v_front_lines,
   input  logic              res_req_vld,
   input  logic [HRES_W-1:0] res_req_val,
   input  logic [VC_W-1:0]   chan_in,
   output logic              fsync,
   output logic              in_act,
   output logic              dummy0,
   output logic [HRES_W-1:0] res_out,
   output logic [VC_W-1:0]   chan_out
);

   if (NUM_DUMMY < 2) begin : g_bad_dummy
      $error("NUM_DUMMY must be at least 2");
   end
   if (NUM_DUMMY >= (1 << VCNT_W)) begin : g_bad_dummy_w
      $error("NUM_DUMMY does not fit the line counter");
   end

   vphase_e           phase_q, phase_n;
   logic [VCNT_W-1:0] vline_q, lim;
   logic [VCNT_W-1:0] vs_e, vb_e, va_e, vf_e;
   logic              line_last, apply;
   logic              pend_q;
   logic [HRES_W-1:0] pend_res_q;

   assign vs_e = (v_sync_lines  < VCNT_W'(V_MIN)) ? VCNT_W'(V_MIN) : v_sync_lines;
   assign vb_e = (v_back_lines  < VCNT_W'(V_MIN)) ? VCNT_W'(V_MIN) : v_back_lines;
   assign va_e = (v_act_lines   < VCNT_W'(V_MIN)) ? VCNT_W'(V_MIN) : v_act_lines;
   assign vf_e = (v_front_lines < VCNT_W'(V_MIN)) ? VCNT_W'(V_MIN) : v_front_lines;

   always_comb begin
      unique case (phase_q)
         VP_SYNC:   begin lim = vs_e;               phase_n = VP_BACK;  end
         VP_BACK:   begin lim = vb_e;               phase_n = VP_ACTIVE; end
         VP_ACTIVE: begin lim = va_e;               phase_n = pend_q ? VP_DUMMY : VP_FRONT; end
         VP_DUMMY:  begin lim = VCNT_W'(NUM_DUMMY); phase_n = VP_FRONT; end
         VP_FRONT:  begin lim = vf_e;               phase_n = VP_SYNC;  end
         default:   begin lim = vs_e;               phase_n = VP_SYNC;  end
      endcase
   end

   assign line_last = (vline_q == lim - VCNT_W'(1));
   assign dummy0    = (phase_q == VP_DUMMY) && (vline_q == '0);
   assign apply     = dummy0 && pulse_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= VP_SYNC;
         vline_q    <= '0;
         chan_out   <= '0;
         res_out    <= HRES_W'(HRES_INIT);
         pend_q     <= 1'b0;
         pend_res_q <= '0;
      end else begin
         if (eol) begin
            if (line_last) begin
               phase_q <= phase_n;
               vline_q <= '0;
               if (phase_q == VP_FRONT) chan_out <= chan_in;
            end else begin
               vline_q <= vline_q + VCNT_W'(1);
            end
         end
         if (res_req_vld) begin
            pend_q     <= 1'b1;
            pend_res_q <= res_req_val;
         end else if (apply) begin
            pend_q <= 1'b0;
         end
         if (apply) res_out <= pend_res_q;
      end
   end

   assign fsync  = (phase_q == VP_BACK) || (phase_q == VP_ACTIVE);
   assign in_act = (phase_q == VP_ACTIVE);

   // R10
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(res_out) || !$stable(chan_out)) |-> !fsync);

   // R10
   frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> ($stable(res_out) && $stable(chan_out)));

   // R7
   res_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_out) |-> (phase_q == VP_DUMMY));

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
   parameter int unsigned HRES_W       = 16,
   parameter int unsigned PORCH_W      = 8,
   parameter int unsigned VCNT_W       = 8,
   parameter int unsigned VC_W         = 2,
   parameter int unsigned PIX_PER_WORD = 4,
   parameter int unsigned NUM_DUMMY    = 2,
   parameter int unsigned HRES_INIT    = 640
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PORCH_W-1:0] h_sync_len,
   input  logic [PORCH_W-1:0] h_back_len,
   input  logic [PORCH_W-1:0] h_front_len,
   input  logic [VCNT_W-1:0]  v_sync_lines,
   input  logic [VCNT_W-1:0]  v_back_lines,
   input  logic [VCNT_W-1:0]  v_act_lines,
   input  logic [VCNT_W-1:0]  v_front_lines,
   input  logic               res_req_vld,
   input  logic [HRES_W-1:0]  res_req_val,
   input  logic [VC_W-1:0]    chan_in,
   output logic               frame_sync,
   output logic               line_sync,
   output logic               data_vld,
   output logic               ctrl_rst_n,
   output logic [HRES_W-1:0]  res_out,
   output logic [VC_W-1:0]    chan_out
);

   if (HRES_INIT >= (1 << HRES_W)) begin : g_bad_init
      $error("HRES_INIT does not fit HRES_W");
   end

   logic [HRES_W-1:0] words, words_line;
   logic              act_win, eol, pulse_last, in_act, dummy0;

   vsg_words #(
      .HRES_W       (HRES_W),
      .PIX_PER_WORD (PIX_PER_WORD)
   ) u_words (
      .hres  (res_out),
      .words (words)
   );

   vsg_hline #(
      .PORCH_W (PORCH_W),
      .WORDS_W (HRES_W)
   ) u_hline (
      .clk         (clk),
      .rst_n       (rst_n),
      .h_sync_len  (h_sync_len),
      .h_back_len  (h_back_len),
      .h_front_len (h_front_len),
      .words       (words),
      .lsync       (line_sync),
      .act_win     (act_win),
      .eol         (eol),
      .pulse_last  (pulse_last),
      .words_q     (words_line)
   );

   vsg_vframe #(
      .VCNT_W    (VCNT_W),
      .HRES_W    (HRES_W),
      .VC_W      (VC_W),
      .NUM_DUMMY (NUM_DUMMY),
      .HRES_INIT (HRES_INIT)
   ) u_vframe (
      .clk           (clk),
      .rst_n         (rst_n),
      .eol           (eol),
      .pulse_last    (pulse_last),
      .v_sync_lines  (v_sync_lines),
      .v_back_lines  (v_back_lines),
      .v_act_lines   (v_act_lines),
      .v_front_lines (v_front_lines),
      .res_req_vld   (res_req_vld),
      .res_req_val   (res_req_val),
      .chan_in       (chan_in),
      .fsync         (frame_sync),
      .in_act        (in_act),
      .dummy0        (dummy0),
      .res_out       (res_out),
      .chan_out      (chan_out)
   );

   assign data_vld   = in_act && act_win;
   assign ctrl_rst_n = !(dummy0 && line_sync);

   // Length of the current unbroken valid run, for the checks below.
   logic [HRES_W-1:0] vrun_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        vrun_q <= '0;
      else if (data_vld) vrun_q <= vrun_q + HRES_W'(1);
      else               vrun_q <= '0;
   end

   // R3
   valid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_vld) |-> (vrun_q == words_line));

   // R8
   rst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rst_n |-> (line_sync && !frame_sync));

endmodule

// File: tb/tb_vid_sync_gen.sv
module tb_vid_sync_gen;

   localparam int PPW   = 4;
   localparam int INITR = 64;
   localparam int NDUM  = 2;

   // hsync, hback, hfront, hres, vsync, vback, vact, vfront
   localparam int VT [0:3][0:7] = '{
      '{3, 4, 2, 16, 1, 2, 3, 2},
      '{0, 1, 5, 17, 0, 1, 2, 0},
      '{2, 2, 2,  1, 2, 0, 0, 3},
      '{5, 3, 4, 30, 1, 1, 4, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  h_sync_len = 8'd2, h_back_len = 8'd2, h_front_len = 8'd2;
   logic [7:0]  v_sync_lines = 8'd1, v_back_lines = 8'd1, v_act_lines = 8'd1, v_front_lines = 8'd1;
   logic        res_req_vld = 1'b0;
   logic [15:0] res_req_val = '0;
   logic [1:0]  chan_in = '0;
   logic        frame_sync, line_sync, data_vld, ctrl_rst_n;
   logic [15:0] res_out;
   logic [1:0]  chan_out;

   always #4 clk = ~clk;

   vid_sync_gen #(
      .HRES_W(16), .PORCH_W(8), .VCNT_W(8), .VC_W(2),
      .PIX_PER_WORD(PPW), .NUM_DUMMY(NDUM), .HRES_INIT(INITR)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .h_sync_len(h_sync_len), .h_back_len(h_back_len), .h_front_len(h_front_len),
      .v_sync_lines(v_sync_lines), .v_back_lines(v_back_lines),
      .v_act_lines(v_act_lines), .v_front_lines(v_front_lines),
      .res_req_vld(res_req_vld), .res_req_val(res_req_val), .chan_in(chan_in),
      .frame_sync(frame_sync), .line_sync(line_sync), .data_vld(data_vld),
      .ctrl_rst_n(ctrl_rst_n), .res_out(res_out), .chan_out(chan_out)
   );

   int n_chk = 0, n_fail = 0;
   int m_fl, m_bl, m_vl, m_rl, m_sw, m_off, m_run, m_per;
   int viol = 0;
   int rr_now = -1, rr_prev = -1;
   logic [15:0] p_res;
   logic [1:0]  p_chan;
   logic        p_rst_o = 1'b1;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int atleast(int v, int m);
      return (v < m) ? m : v;
   endfunction

   // Output monitor: outputs settle after posedge, sampled at negedge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_sync && (res_out != p_res || chan_out != p_chan)) viol++;
         if (ctrl_rst_n && !p_rst_o) begin
            rr_now  = int'(res_out);
            rr_prev = int'(p_res);
         end
      end
      p_res   = res_out;
      p_chan  = chan_out;
      p_rst_o = ctrl_rst_n;
   end

   task automatic wait_rise();
      logic pf;
      pf = frame_sync;
      forever begin
         @(negedge clk);
         if (frame_sync && !pf) break;
         pf = frame_sync;
      end
   endtask

   // Called at a frame_sync rise; returns at the next one.
   task automatic scan_frame();
      int cyc = 0, rise_c = 0, cur_sw = 0, cur_run = 0, cur_off = 0;
      bit lv = 0, got = 0;
      logic pl = 1'b0, pf = 1'b1;
      m_fl = 0; m_bl = 0; m_vl = 0; m_rl = 0;
      m_sw = 0; m_off = 0; m_run = 0; m_per = 0;
      forever begin
         if (line_sync && !pl) begin
            if (lv && !got) begin
               got = 1; m_sw = cur_sw; m_off = cur_off; m_run = cur_run; m_per = cyc - rise_c;
            end
            rise_c = cyc; cur_sw = 0; cur_run = 0; lv = 0;
            if (frame_sync) m_fl++; else m_bl++;
         end
         if (line_sync) cur_sw++;
         if (data_vld) begin
            if (!lv) begin lv = 1; cur_off = cyc - rise_c; m_vl++; end
            cur_run++;
         end
         if (!ctrl_rst_n) m_rl++;
         pl = line_sync; pf = frame_sync;
         @(negedge clk); cyc++;
         if (frame_sync && !pf) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int hs, hb, hf, vs, vb, va, vf, wd;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 frame_sync", int'(frame_sync), 0);
      chk("R1 line_sync", int'(line_sync), 0);
      chk("R1 data_vld", int'(data_vld), 0);
      chk("R1 ctrl_rst_n", int'(ctrl_rst_n), 1);
      chk("R1 res_out", int'(res_out), INITR);
      chk("R1 chan_out", int'(chan_out), 0);

      for (int v = 0; v < 4; v++) begin
         rst_n = 1'b0;
         h_sync_len = 8'(VT[v][0]); h_back_len = 8'(VT[v][1]); h_front_len = 8'(VT[v][2]);
         v_sync_lines = 8'(VT[v][4]); v_back_lines = 8'(VT[v][5]);
         v_act_lines = 8'(VT[v][6]); v_front_lines = 8'(VT[v][7]);
         repeat (2) @(negedge clk);
         rst_n = 1'b1;
         rr_now = -1; rr_prev = -1;
         res_req_val = 16'(VT[v][3]); res_req_vld = 1'b1;
         @(negedge clk);
         res_req_vld = 1'b0;
         hs = atleast(VT[v][0], 2); hb = atleast(VT[v][1], 2); hf = atleast(VT[v][2], 2);
         vs = atleast(VT[v][4], 1); vb = atleast(VT[v][5], 1);
         va = atleast(VT[v][6], 1); vf = atleast(VT[v][7], 1);
         wd = (VT[v][3] + PPW - 1) / PPW;
         wait_rise();
         // Frame A: old width, request pending, dummy lines in its blanking
         scan_frame();
         chk("R5 frame lines A", m_fl, vb + va);
         chk("R5 active lines A", m_vl, va);
         chk("R7 blank lines with dummies", m_bl, vf + vs + NDUM);
         chk("R8 ctrl reset low cycles", m_rl, hs);
         chk("R8 res_out at reset end", rr_now, VT[v][3]);
         chk("R8 res_out before reset end", rr_prev, INITR);
         chk("R3 old width run", m_run, (INITR + PPW - 1) / PPW);
         // Frame B: new width, no request pending
         scan_frame();
         chk("R3 valid run words", m_run, wd);
         chk("R2 valid offset", m_off, hs + hb);
         chk("R4 sync width", m_sw, hs);
         chk("R2 line period", m_per, hs + hb + wd + hf);
         chk("R7 blank lines no request", m_bl, vf + vs);
         chk("R8 no ctrl reset", m_rl, 0);
         chk("R5 frame lines B", m_fl, vb + va);
         chk("R5 active lines B", m_vl, va);
      end

      // R6, R9: mid-frame request and channel change are held off
      repeat (3) @(negedge clk);
      chk("R6 frame_sync high at request", int'(frame_sync), 1);
      res_req_val = 16'd40; res_req_vld = 1'b1; chan_in = 2'd2;
      @(negedge clk);
      res_req_vld = 1'b0;
      while (frame_sync) @(negedge clk);
      chk("R6 res_out unchanged in frame", int'(res_out), VT[3][3]);
      chk("R9 chan_out unchanged in frame", int'(chan_out), 0);
      wait_rise();
      chk("R6 res_out applied next blanking", int'(res_out), 40);
      chk("R9 chan_out updated", int'(chan_out), 2);
      scan_frame();
      chk("R3 run after mid-frame request", m_run, 10);
      chk("R10 no change while frame_sync high", viol, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule